// File: doc/BRIEF.md
# Bus-Kicked Watchdog Timer

This block watches over a host by listening to the two open-drain lines of an I2C-style bus (clock line SCL, data line SDA). Both lines arrive already synchronised to the block clock. Each time the host opens a transfer with a START condition, the watchdog is restarted. A START is SDA falling while SCL is high. If no START comes within the selected period, the block drives its timeout output high for a fixed reset interval. When that interval ends, the output drops and a new period is timed from zero.

A 2-bit code selects the period, and the same code also sets the reset interval:

| Code | Period | Reset interval |
|------|--------|----------------|
| 00 | `PER_LONG` | `HOLD_LONG` |
| 01 | `PER_MID` | `HOLD_LONG` |
| 10 | `PER_SHORT` | `HOLD_SHORT` |
| 11 | watchdog disabled | none |

All values are counted in clock cycles. The default parameters assume a 1 µs clock, which gives 1.4 s, 200 ms and 25 ms periods, and 200 ms and 25 ms reset intervals. The code register is written elsewhere and is driven onto `wd_code_i`.

A START only counts if SCL has already been high for at least `MIN_HIGH` cycles. This rejects bus pulses that are too short. A STOP (SDA rising while SCL is high) never restarts the watchdog.

The controller is a three-state machine:

- `ST_OFF`: disabled, output low.
- `ST_COUNT`: timing the period.
- `ST_HOLD`: timeout output high.

Its transitions, in order of priority:

1. Any code change moves the machine to `ST_OFF` (new code 11) or to `ST_COUNT` with the counter at zero (any other new code).
2. In `ST_COUNT`, a START clears the counter (kick).
3. In `ST_COUNT`, a counter at the period limit moves the machine to `ST_HOLD` (expire).
4. In `ST_HOLD`, a counter at the hold limit moves the machine back to `ST_COUNT` at zero (release).

Top module: `wdt_bus_watchdog`

## Requirements
- R1: After reset, `wdo_o` is low and the stored code is 11, so the block is disabled. A code other than 11 presented after reset counts as a code change.
- R2: With no START, `wdo_o` rises on the (P+1)th rising clock edge after a new code is presented. P is `PER_LONG` for code 00, `PER_MID` for 01 and `PER_SHORT` for 10.
- R3: `wdo_o` stays high for exactly `HOLD_LONG` cycles (codes 00 and 01) or `HOLD_SHORT` cycles (code 10). It then stays low for exactly P cycles before the next timeout, if no START arrives.
- R4: A START seen while the period is being timed restarts the period from zero. Repeated STARTs spaced closer than the period keep `wdo_o` low.
- R5: A START is accepted only if SCL was sampled high on at least `MIN_HIGH` consecutive clock edges before the edge on which SDA is first sampled low. A shorter SCL-high pulse followed by SDA falling leaves the timeout schedule unchanged.
- R6: A STOP (SDA rising while SCL is high) does not restart the period.
- R7: A START arriving while `wdo_o` is high is ignored, and the reset interval keeps its full length.
- R8: Code 11 forces `wdo_o` low by the next clock edge. No timeout occurs and STARTs have no effect while the code stays 11.
- R9: Changing to another code that is not 11 restarts the period from zero, also during a reset interval. In that case `wdo_o` falls by the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line |
| wd_code_i | input | 2 | Period code (00, 01, 10 active; 11 off) |
| wdo_o | output | 1 | Watchdog timeout, high during the reset interval |

## Verification
A wrong counter value or a wrong state only becomes visible at `wdo_o`, so the bench compares `wdo_o` with a behavioural model on every cycle. A missed or spurious kick moves the next rising edge of `wdo_o` by up to a whole period, and a wrong hold count changes the pulse width within one reset interval. A START detector that misreads SCL or SDA shows up as a timeout that arrives on time when it should have been pushed back, or late when it should have come on time. For that reason, each pattern of bus traffic is timed against the cycle of the expected `wdo_o` edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } wdt_state_e;

    localparam logic [1:0] CODE_OFF   = 2'b11;
    localparam logic [1:0] CODE_LONG  = 2'b00;
    localparam logic [1:0] CODE_MID   = 2'b01;
    localparam logic [1:0] CODE_SHORT = 2'b10;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/wdt_start_det.sv
module wdt_start_det #(
    parameter int MIN_HIGH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic kick_o
);
    localparam int HI_W = (MIN_HIGH < 1) ? 1 : $clog2(MIN_HIGH + 1);
    localparam logic [HI_W-1:0] HI_SAT = HI_W'(MIN_HIGH);

    logic            scl_q;
    logic            sda_q;
    logic [HI_W-1:0] hi_cnt_q;
    logic            start_seen;
    logic            hi_ok;

    assign hi_ok      = (hi_cnt_q >= HI_SAT);
    assign start_seen = scl_i && scl_q && sda_q && !sda_i && hi_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            hi_cnt_q <= '0;
            kick_o   <= 1'b0;
        end else begin
            scl_q  <= scl_i;
            sda_q  <= sda_i;
            kick_o <= start_seen;
            if (!scl_i) begin
                hi_cnt_q <= '0;
            end else if (hi_cnt_q != HI_SAT) begin
                hi_cnt_q <= hi_cnt_q + 1'b1;
            end
        end
    end

    AST_STOP_NO_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && scl_q && !sda_q && sda_i) |=> !kick_o); // R6

    AST_SHORT_HIGH_NO_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_q) |=> !kick_o); // R5

endmodule

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 21,
    parameter int PER_LONG   = 1400000,
    parameter int PER_MID    = 200000,
    parameter int PER_SHORT  = 25000,
    parameter int HOLD_LONG  = 200000,
    parameter int HOLD_SHORT = 25000
) (
    input  logic [1:0]       code_i,
    output logic [CNT_W-1:0] per_lim_o,
    output logic [CNT_W-1:0] hold_lim_o
);
    logic [CNT_W-1:0] per_tab  [4];
    logic [CNT_W-1:0] hold_tab [4];

    function automatic int per_of(input int c);
        unique case (c)
            0:       return PER_LONG - 1;
            1:       return PER_MID - 1;
            2:       return PER_SHORT - 1;
            default: return 0;
        endcase
    endfunction

    function automatic int hold_of(input int c);
        unique case (c)
            0, 1:    return HOLD_LONG - 1;
            2:       return HOLD_SHORT - 1;
            default: return 0;
        endcase
    endfunction

    for (genvar g = 0; g < 4; g++) begin : g_tab
        assign per_tab[g]  = CNT_W'(per_of(g));
        assign hold_tab[g] = CNT_W'(hold_of(g));
    end

    assign per_lim_o  = per_tab[code_i];
    assign hold_lim_o = hold_tab[code_i];

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       code_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] per_lim_i,
    input  logic [CNT_W-1:0] hold_lim_i,
    output logic             wdo_o
);
    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       code_q;
    logic             code_chg;

    assign code_chg = (code_i != code_q);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (code_chg) begin
            cnt_d   = '0;
            state_d = (code_i == CODE_OFF) ? ST_OFF : ST_COUNT;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cnt_d = '0;
                end
                ST_COUNT: begin
                    if (kick_i) begin
                        cnt_d = '0;
                    end else if (cnt_q == per_lim_i) begin
                        state_d = ST_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == hold_lim_i) begin
                        state_d = ST_COUNT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            code_q  <= CODE_OFF;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            code_q  <= code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdo_o <= 1'b0;
        end else begin
            wdo_o <= (state_d == ST_HOLD);
        end
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == CODE_OFF) |=> !wdo_o); // R8

    AST_HOLD_IGNORES_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wdo_o && kick_i && !code_chg && cnt_q != hold_lim_i) |=> wdo_o); // R7

    AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && kick_i && !code_chg) |=> (cnt_q == '0 && !wdo_o)); // R4

    AST_CODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (code_chg && code_i != CODE_OFF) |=> (state_q == ST_COUNT && cnt_q == '0 && !wdo_o)); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !code_chg) |-> (cnt_q <= per_lim_i)); // R2

    AST_RESET_STATE: assert property (@(posedge clk)
        (!rst_n) |=> (!wdo_o)); // R1

endmodule

// File: rtl/wdt_bus_watchdog.sv
module wdt_bus_watchdog
    import wdt_pkg::*;
#(
    parameter int PER_LONG   = 1400000,
    parameter int PER_MID    = 200000,
    parameter int PER_SHORT  = 25000,
    parameter int HOLD_LONG  = 200000,
    parameter int HOLD_SHORT = 25000,
    parameter int MIN_HIGH   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] wd_code_i,
    output logic       wdo_o
);
    localparam int MAX_LIM = max3(max3(PER_LONG, PER_MID, PER_SHORT), HOLD_LONG, HOLD_SHORT);
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic             kick;
    logic [CNT_W-1:0] per_lim;
    logic [CNT_W-1:0] hold_lim;

    wdt_start_det #(
        .MIN_HIGH (MIN_HIGH)
    ) i_start_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .kick_o (kick)
    );

    wdt_limit_sel #(
        .CNT_W      (CNT_W),
        .PER_LONG   (PER_LONG),
        .PER_MID    (PER_MID),
        .PER_SHORT  (PER_SHORT),
        .HOLD_LONG  (HOLD_LONG),
        .HOLD_SHORT (HOLD_SHORT)
    ) i_limit_sel (
        .code_i     (wd_code_i),
        .per_lim_o  (per_lim),
        .hold_lim_o (hold_lim)
    );

    wdt_ctrl #(
        .CNT_W (CNT_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (wd_code_i),
        .kick_i     (kick),
        .per_lim_i  (per_lim),
        .hold_lim_i (hold_lim),
        .wdo_o      (wdo_o)
    );

endmodule

// File: tb/test_wdt_bus_watchdog.sv
module test_wdt_bus_watchdog;
    localparam int P_L = 400, P_M = 200, P_S = 60;
    localparam int H_L = 50,  H_S = 20,  MINH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic [1:0] code = 2'b11;
    logic wdo;

    int checks = 0, fails = 0;
    bit run_cmp = 0;
    bit saw_wdo = 0;

    always #2 clk = ~clk;

    wdt_bus_watchdog #(
        .PER_LONG(P_L), .PER_MID(P_M), .PER_SHORT(P_S),
        .HOLD_LONG(H_L), .HOLD_SHORT(H_S), .MIN_HIGH(MINH)
    ) i_wdt_bus_watchdog (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .wd_code_i(code), .wdo_o(wdo)
    );

    // behavioural reference model
    int m_hi; bit m_scl, m_sda, m_kick; bit [1:0] m_code;
    int m_st; int m_cnt; bit m_wdo;
    function automatic int per_for(bit [1:0] c);
        return (c == 2'b00) ? P_L : (c == 2'b01) ? P_M : P_S;
    endfunction
    function automatic int hold_for(bit [1:0] c);
        return (c == 2'b10) ? H_S : H_L;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hi = 0; m_scl = 1; m_sda = 1; m_kick = 0;
            m_code = 2'b11; m_st = 0; m_cnt = 0; m_wdo = 0;
        end else begin
            if (code != m_code) begin
                m_cnt = 0;
                m_st = (code == 2'b11) ? 0 : 1;
            end else if (m_st == 1) begin
                if (m_kick) m_cnt = 0;
                else if (m_cnt == per_for(code) - 1) begin m_st = 2; m_cnt = 0; end
                else m_cnt++;
            end else if (m_st == 2) begin
                if (m_cnt == hold_for(code) - 1) begin m_st = 1; m_cnt = 0; end
                else m_cnt++;
            end
            m_wdo = (m_st == 2);
            m_code = code;
            m_kick = scl && m_scl && m_sda && !sda && (m_hi >= MINH);
            m_hi = scl ? m_hi + 1 : 0;
            m_scl = scl; m_sda = sda;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (wdo) saw_wdo = 1;
        if (run_cmp) check(wdo == m_wdo, "R2/R3/R4 cycle model", wdo, m_wdo);
    end

    task automatic bus(input bit s, input bit d, input int n);
        scl = s; sda = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic start_seq();
        bus(1, 0, 3); bus(0, 0, 3); bus(0, 1, 3); bus(1, 1, 4);
        bus(1, 0, 3); bus(0, 0, 3); bus(0, 1, 3); bus(1, 1, 2);
    endtask

    task automatic measure_rise(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!wdo && n < 5000);
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (wdo && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (!wdo && n < 5000) begin @(negedge clk); n++; end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0 (timeout)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        run_cmp = 1;
        check(wdo == 0, "R1 reset output", wdo, 0);
        repeat (500) @(negedge clk);
        check(wdo == 0 && !saw_wdo, "R1 disabled after reset", saw_wdo, 0);

        // R8: traffic while code is 11
        saw_wdo = 0;
        for (int i = 0; i < 10; i++) begin bus(1, 1, 20); start_seq(); end
        check(!saw_wdo, "R8 no timeout while off", saw_wdo, 0);

        // R2 / R3 code 10
        code = 2'b10;
        measure_rise(n); check(n == P_S + 1, "R2 code 10 period", n, P_S + 1);
        measure_high(n); check(n == H_S, "R3 code 10 hold", n, H_S);
        measure_low(n);  check(n == P_S, "R3 gap after hold", n, P_S);
        measure_high(n);

        // R9 then R2 code 01 and 00
        repeat (10) @(negedge clk);
        code = 2'b01;
        measure_rise(n); check(n == P_M + 1, "R9 R2 code 01 period", n, P_M + 1);
        measure_high(n); check(n == H_L, "R3 code 01 hold", n, H_L);
        repeat (7) @(negedge clk);
        code = 2'b00;
        measure_rise(n); check(n == P_L + 1, "R2 code 00 period", n, P_L + 1);
        measure_high(n); check(n == H_L, "R3 code 00 hold", n, H_L);

        // R4: a kick delays the timeout
        code = 2'b10;
        fork
            measure_rise(n);
            begin bus(1, 1, 30); start_seq(); end
        join
        check(n > P_S + 1 + 30, "R4 kick delays timeout", n, P_S + 31);
        measure_high(n);

        // R4: continuous kicks keep the output low
        repeat (5) @(negedge clk);
        code = 2'b01; @(negedge clk);
        code = 2'b10; @(negedge clk);
        saw_wdo = 0;
        for (int i = 0; i < 10; i++) begin bus(1, 1, 20); start_seq(); end
        check(!saw_wdo, "R4 steady kicks prevent timeout", saw_wdo, 0);

        // R5: too-short SCL high is not a START
        code = 2'b01; @(negedge clk);
        code = 2'b10;
        fork
            measure_rise(n);
            begin bus(1, 1, 20); bus(0, 1, 3); bus(1, 1, 2); bus(1, 0, 3);
                  bus(0, 0, 3); bus(0, 1, 2); bus(1, 1, 3); end
        join
        check(n == P_S + 1, "R5 short high ignored", n, P_S + 1);
        measure_high(n);

        // R6: STOP is not a restart
        repeat (3) @(negedge clk);
        code = 2'b01; @(negedge clk);
        code = 2'b10;
        fork
            measure_rise(n);
            begin bus(1, 1, 20); bus(0, 1, 2); bus(0, 0, 2); bus(1, 0, 4); bus(1, 1, 4); end
        join
        check(n == P_S + 1, "R6 stop ignored", n, P_S + 1);

        // R7: START during hold ignored
        fork
            measure_high(n);
            begin bus(1, 0, 3); bus(0, 0, 3); bus(0, 1, 2); bus(1, 1, 2); end
        join
        check(n == H_S, "R7 hold unchanged by start", n, H_S);

        // R8: code 11 during hold
        measure_rise(n);
        repeat (5) @(negedge clk);
        code = 2'b11;
        @(negedge clk);
        check(wdo == 0, "R8 off drops output", wdo, 0);
        saw_wdo = 0;
        repeat (300) @(negedge clk);
        check(!saw_wdo, "R8 stays off", saw_wdo, 0);

        // R9: new code during hold
        code = 2'b10;
        measure_rise(n);
        repeat (5) @(negedge clk);
        code = 2'b01;
        @(negedge clk);
        check(wdo == 0, "R9 code change drops output", wdo, 0);
        measure_rise(n); check(n == P_M, "R9 restart from hold", n, P_M);
        measure_high(n);

        run_cmp = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule